// File: doc/BRIEF.md
# Serial Flash Slave Front End

This block sits behind the pins of a serial memory device and turns the bit stream from a host into accesses on a simple array port. The host selects the device with an active-low chip select. It then clocks in a command byte and, for a read, three address bytes. The block replies by streaming array bytes back on the serial output. All pin inputs are brought into the system clock domain through a short synchronizer, and SCLK edges are detected there. The block expects SCLK to stay high and low for at least six system clocks each.

SI is sampled and SO is updated on the same rising SCLK edge, and bytes move most-significant bit first in both directions. For a read, the block presents the assembled address with a one-cycle fetch strobe. The array answers one clock later. After each byte that has been shifted out, the address steps to the next location, wrapping at the top of the space. Any other command code is decoded onto a strobe and then the block waits for deselect. An active-low hardware reset pin releases SO at once and blocks all SCLK activity. If it stays low for a programmable number of clocks, it also aborts the transfer and returns the controller to waiting for a command byte.

Top module: `sfl_slave_fe`

## Requirements
- R1: After eight rising SCLK edges with chip select low, the byte sampled on SI (first bit = bit 7) appears on `cmd_code`, and `cmd_stb` pulses for exactly one clock.
- R2: Command code 0x03 is a read. The next three bytes form a 24-bit value, sent high byte first. Its low 23 bits become the array address, and bit 23 is ignored. One `mem_rd` pulse is issued with that value on `mem_addr`.
- R3: Read data leaves on `so`, bit 7 first, with one bit per rising SCLK edge. The first data bit is driven on the first rising edge after the last address bit, and `so_en` stays low before that edge.
- R4: Each time eight data bits have been driven, the address advances by one, with 0x7FFFFF followed by 0x000000, and a new fetch is issued.
- R5: A command code other than 0x03 pulses `cmd_stb` with that code. It causes no `mem_rd`, leaves `so_en` low and gives no further `cmd_stb` until chip select rises.
- R6: Chip select high drops `so_en` within three clocks and discards any partly received bits. The first byte after the next select is treated as a command.
- R7: While `hw_rst_n` is low, `so_en` falls within three clocks and SCLK edges are ignored, so that no `cmd_stb` and no `mem_rd` occur.
- R8: When `hw_rst_n` stays low for at least TRP_CLKS clocks, the transfer in progress is abandoned. After release, with chip select still low, the next byte is taken as a command.
- R9: A low pulse on `hw_rst_n` shorter than TRP_CLKS clocks, with no SCLK edge during it, leaves the transfer in progress intact.
- R10: After system reset, `so_en`, `cmd_stb` and `mem_rd` are low and `mem_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hw_rst_n | input | 1 | Active-low hardware reset pin |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for the SO pad (0 = high impedance) |
| cmd_stb | output | 1 | One-clock pulse when a command byte completes |
| cmd_code | output | 8 | Last command byte received |
| byte_stb | output | 1 | One-clock pulse for each completed command or address byte |
| mem_rd | output | 1 | One-clock array fetch strobe |
| mem_addr | output | ADDR_W | Array address |
| mem_rdata | input | 8 | Array read data, valid the clock after `mem_rd` |

## Verification
A bit counter that is out of step shows on SO within one byte as data shifted by whole bit positions. It shows on `mem_addr` as a misassembled address as soon as the third address byte ends. A controller left in the wrong state after a reset or deselect turns the next command byte into address or data. That yields a wrong `cmd_code`, a missing `cmd_stb` or an early `mem_rd` within eight SCLK edges. A faulty address step is caught on the byte after the step, and the wrap case on the byte after the top address. Output-enable faults are visible on `so_en` within three clocks of the pin change.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } sfl_state_e;
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sfl_rst_filter.sv
module sfl_rst_filter #(
  parameter int TRP_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  output logic hold
);
  localparam int CW = $clog2(TRP_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TRP_CLKS);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (!pin_low)        low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign hold = pin_low && (low_cnt == LIMIT);

  // R9
  short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_low |=> !hold);
endmodule

// File: rtl/sfl_slave_fe.sv
module sfl_slave_fe
  import sfl_pkg::*;
#(
  parameter int         ADDR_W      = 23,
  parameter int         ADDR_BYTES  = 3,
  parameter logic [7:0] RD_CODE     = 8'h03,
  parameter int         TRP_CLKS    = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hw_rst_n,
  output logic              so,
  output logic              so_en,
  output logic              cmd_stb,
  output logic [7:0]        cmd_code,
  output logic              byte_stb,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int SH_W = ADDR_BYTES * 8;
  localparam int ABW  = $clog2(ADDR_BYTES + 1);
  localparam logic [ABW-1:0]    LAST_AB  = ABW'(ADDR_BYTES - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return (a == ADDR_TOP) ? '0 : a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] pick_addr(input logic [SH_W-1:0] raw);
    return raw[ADDR_W-1:0];
  endfunction

  // pin synchronizer: {hw_rst_n, cs_n, si, sclk}
  logic [3:0] pins_s;
  sfl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({hw_rst_n, cs_n, si, sclk}),
    .dout (pins_s)
  );

  wire sclk_s  = pins_s[0];
  wire si_s    = pins_s[1];
  wire cs_s    = pins_s[2];
  wire pin_low = ~pins_s[3];

  logic rst_hold;
  sfl_rst_filter #(.TRP_CLKS(TRP_CLKS)) u_rfilt (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_low(pin_low),
    .hold   (rst_hold)
  );

  sfl_state_e         state;
  logic               sclk_q;
  logic [2:0]         bitcnt;
  logic [6:0]         rx_sh;
  logic [SH_W-9:0]    asm_q;
  logic [ABW-1:0]     abyte;
  logic [7:0]         tx;
  logic               rd_pend;

  // named events for checking
  wire       abort          = cs_s | rst_hold;
  wire       sclk_rise      = sclk_s & ~sclk_q & ~cs_s & ~pin_low;
  wire [7:0] rx_byte        = {rx_sh, si_s};
  wire       byte_end       = sclk_rise && (bitcnt == 3'd7);
  wire       data_byte_done = byte_end && (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      sclk_q   <= 1'b0;
      bitcnt   <= '0;
      rx_sh    <= '0;
      asm_q    <= '0;
      abyte    <= '0;
      tx       <= '0;
      rd_pend  <= 1'b0;
      so       <= 1'b0;
      so_en    <= 1'b0;
      cmd_stb  <= 1'b0;
      cmd_code <= '0;
      byte_stb <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
    end else begin
      sclk_q   <= sclk_s;
      cmd_stb  <= 1'b0;
      byte_stb <= 1'b0;
      mem_rd   <= 1'b0;
      rd_pend  <= mem_rd;
      if (rd_pend) tx <= mem_rdata;

      if (abort) begin
        state  <= ST_CMD;
        bitcnt <= '0;
        abyte  <= '0;
        so_en  <= 1'b0;
      end else begin
        if (pin_low) so_en <= 1'b0;
        if (sclk_rise) begin
          bitcnt <= bitcnt + 3'd1;
          rx_sh  <= rx_byte[6:0];
          unique case (state)
            ST_CMD: if (byte_end) begin
              cmd_code <= rx_byte;
              cmd_stb  <= 1'b1;
              byte_stb <= 1'b1;
              abyte    <= '0;
              state    <= (rx_byte == RD_CODE) ? ST_ADDR : ST_SKIP;
            end
            ST_ADDR: if (byte_end) begin
              byte_stb <= 1'b1;
              asm_q    <= {asm_q[SH_W-17:0], rx_byte};
              if (abyte == LAST_AB) begin
                mem_addr <= pick_addr({asm_q, rx_byte});
                mem_rd   <= 1'b1;
                state    <= ST_DATA;
              end else begin
                abyte <= abyte + 1'b1;
              end
            end
            ST_DATA: begin
              so    <= tx[7];
              tx    <= {tx[6:0], 1'b0};
              so_en <= 1'b1;
              if (byte_end) begin
                mem_addr <= next_addr(mem_addr);
                mem_rd   <= 1'b1;
              end
            end
            ST_SKIP: ;
            default: ;
          endcase
        end
      end
    end
  end

  // R6
  so_off_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_en);

  // R7
  so_off_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_low |=> !so_en);

  // R8
  rst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> (state == ST_CMD && bitcnt == 3'd0));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_byte_done |=> (mem_rd && mem_addr == next_addr($past(mem_addr))));

  // R1
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R5
  skip_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!mem_rd && !so_en));
endmodule

// File: tb/test_sfl_slave_fe.sv
`timescale 1ns/1ps
module test_sfl_slave_fe;
  localparam int HALF = 6;
  localparam logic [7:0] RD = 8'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        si = 1'b0;
  logic        hw_rst_n = 1'b1;
  logic        so, so_en, cmd_stb, byte_stb, mem_rd;
  logic [7:0]  cmd_code;
  logic [22:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int nchk = 0;
  int nerr = 0;
  int cmd_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] last_code = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sfl_slave_fe i_sfl_slave_fe (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .hw_rst_n(hw_rst_n), .so(so), .so_en(so_en), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .byte_stb(byte_stb), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [22:0] a);
    return a[7:0] ^ a[22:15] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  always @(negedge clk) begin
    if (cmd_stb) begin cmd_cnt++; last_code = cmd_code; end
    if (mem_rd) rd_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic so_b, output logic en_b);
    si = b;
    repeat (HALF) @(negedge clk);
    so_b = so;
    en_b = so_en;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic sb, eb;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], sb, eb);
  endtask

  task automatic do_read(input logic [23:0] sent, input int n, input bit own_cs,
                         input bit glitch, input string tag);
    int c0, r0, bad_en;
    logic sb, eb;
    logic [7:0] got;
    logic [22:0] a;
    if (!own_cs) begin cs_n = 1'b0; repeat (4) @(negedge clk); end
    c0 = cmd_cnt; r0 = rd_cnt; bad_en = 0;
    send_byte(RD);
    chk(cmd_cnt == c0 + 1 && last_code == RD, {"R1 read code ", tag}, last_code, RD);
    send_byte(sent[23:16]);
    if (glitch) begin
      hw_rst_n = 1'b0; repeat (2) @(negedge clk);
      hw_rst_n = 1'b1; repeat (4) @(negedge clk);
    end
    send_byte(sent[15:8]);
    send_byte(sent[7:0]);
    chk(mem_addr == sent[22:0] && rd_cnt == r0 + 1, {"R2 address ", tag}, mem_addr, sent[22:0]);
    a = sent[22:0];
    bit_xfer(1'b0, sb, eb);
    chk(!eb, {"R3 so_en before data ", tag}, eb, 0);
    for (int k = 0; k < n; k++) begin
      got = 8'h00;
      for (int b = 0; b < 8; b++) begin
        bit_xfer(1'b0, sb, eb);
        got = {got[6:0], sb};
        if (!eb) bad_en++;
      end
      chk(got == memf(a) && bad_en == 0, {"R3 R4 data byte ", tag}, got, memf(a));
      a = a + 23'd1;
    end
    chk(rd_cnt == r0 + 1 + n, {"R4 fetch count ", tag}, rd_cnt - r0, 1 + n);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!so_en, {"R6 release on deselect ", tag}, so_en, 0);
  endtask

  localparam logic [27:0] RD_VEC [4] = '{
    {24'h000000, 4'd2},
    {24'h923456, 4'd2},
    {24'h7FFFFE, 4'd3},
    {24'h2AAAAA, 4'd1}
  };

  initial begin
    repeat (5000 * 20) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int c0, r0;
    logic sb, eb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!so_en && !cmd_stb && !mem_rd && mem_addr == 0, "R10 reset state",
        {so_en, cmd_stb, mem_rd}, 0);

    // table of reads
    for (int v = 0; v < 4; v++) begin
      do_read(RD_VEC[v][27:4], int'(RD_VEC[v][3:0]), 1'b0, 1'b0, "vector");
      repeat (4) @(negedge clk);
    end

    // R5 non-read command
    cs_n = 1'b0; repeat (4) @(negedge clk);
    c0 = cmd_cnt; r0 = rd_cnt;
    send_byte(8'h9F);
    chk(cmd_cnt == c0 + 1 && last_code == 8'h9F, "R5 other code strobe", last_code, 8'h9F);
    eb = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic e1;
      bit_xfer(RD[i], sb, e1);
      eb = eb | e1;
    end
    chk(!eb && rd_cnt == r0 && cmd_cnt == c0 + 1, "R5 no fetch, no output", rd_cnt - r0, 0);
    cs_n = 1'b1; repeat (5) @(negedge clk);

    // R6 partial command dropped by deselect
    cs_n = 1'b0; repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, sb, eb);
    cs_n = 1'b1; repeat (5) @(negedge clk);
    do_read(24'h0ABCDE, 1, 1'b0, 1'b0, "R6 after partial");

    // R7 R8 reset in the middle of a command
    cs_n = 1'b0; repeat (4) @(negedge clk);
    send_byte(RD);
    send_byte(8'h12);
    hw_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!so_en, "R7 so_en low in reset", so_en, 0);
    c0 = cmd_cnt; r0 = rd_cnt;
    for (int i = 0; i < 10; i++) bit_xfer(1'b1, sb, eb);
    chk(cmd_cnt == c0 && rd_cnt == r0, "R7 edges ignored in reset", cmd_cnt - c0, 0);
    hw_rst_n = 1'b1; repeat (4) @(negedge clk);
    do_read(24'h345678, 2, 1'b1, 1'b0, "R8 after abort");

    // R7 reset during data output
    cs_n = 1'b0; repeat (4) @(negedge clk);
    send_byte(RD); send_byte(8'h00); send_byte(8'h01); send_byte(8'h00);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, sb, eb);
    chk(eb, "R3 driving during data", eb, 1);
    hw_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!so_en, "R7 release mid data", so_en, 0);
    r0 = rd_cnt;
    for (int i = 0; i < 16; i++) bit_xfer(1'b0, sb, eb);
    chk(rd_cnt == r0 && !so_en, "R7 no fetch in reset", rd_cnt - r0, 0);
    hw_rst_n = 1'b1;
    cs_n = 1'b1; repeat (5) @(negedge clk);

    // R9 short pulse keeps the transfer
    do_read(24'h5A0F33, 2, 1'b0, 1'b1, "R9 short pulse");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule